// File: doc/BRIEF.md
# Extension Instruction Pre-Decoder

This block sits between instruction fetch and a five-stage RISC pipeline with 32-bit instructions. It inspects every fetched word. A word whose 6-bit primary opcode matches one reserved value is an extension instruction. Every other word is native.

Native words are handed to the pipeline unchanged. For an extension word, the 5-bit sub-instruction code and the 6-bit operation code are sent to the extension interface. The pipeline receives a substitute word in its place. That word is a register-register OR, which cannot raise an exception. It keeps the source and destination register fields, so the register file reads the operands and the hazard logic tracks the destination as for any ALU instruction. A write-back select flag travels with the substitute word. It tells the result multiplexer to take the destination data from the extension interface instead of the ALU.

Software encodes any register argument that an extension instruction does not use as register 0. Register 0 is never written, so these fields cause no forwarding and no stall. All outputs are registered, one cycle after the fetched word.

Top module: `xdec_predecode`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is zero.
- R2: A valid word whose bits 31:26 differ from EXT_PRIMARY (default 6'h3E) appears on issue_word bit-identical one cycle later, with issue_valid high.
- R3: A word is treated as an extension instruction exactly when bits 31:26 equal EXT_PRIMARY.
- R4: For a valid extension word, issue_word one cycle later has bits 31:26 = 0 and bits 5:0 = SUBST_FUNCT (default 6'h25, OR). Bits 25:6 are copied unchanged, and issue_valid is high.
- R5: For each valid extension word, xif_strobe is high for exactly that one issue cycle. In the same cycle, xif_sub carries input bits 10:6 and xif_op carries input bits 5:0.
- R6: wb_from_xif is high one cycle after a valid extension word and low after a native word or a bubble.
- R7: When fetch_valid is low, the next cycle shows issue_valid = 0, issue_word = 0, xif_strobe = 0 and wb_from_xif = 0, whatever fetch_word holds.
- R8: Whenever xif_strobe is low, xif_sub and xif_op are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | fetch_word holds a real instruction |
| fetch_word | input | 32 | Fetched instruction word |
| issue_valid | output | 1 | issue_word is a real instruction |
| issue_word | output | 32 | Word sent to the pipeline (native or substitute) |
| xif_strobe | output | 1 | One-cycle pulse per extension instruction |
| xif_sub | output | 5 | Extension sub-instruction code |
| xif_op | output | 6 | Extension operation code |
| wb_from_xif | output | 1 | Destination write data comes from the extension interface |

## Verification
Every piece of state in this block is the registered stage itself, so any error shows at the ports in the very next cycle. The error then lasts only one cycle, because the next fetched word overwrites it.

A wrong classification appears at once in two places: the opcode and function bits of issue_word, and the strobe. A stale or leaking field shows as nonzero xif_sub or xif_op while no strobe is present. A bubble that is not cleared shows as a nonzero issue_word behind a low issue_valid.

// File: rtl/xdec_pkg.sv
package xdec_pkg;
    localparam int WORD_W  = 32;
    localparam int PRIM_W  = 6;
    localparam int SUB_W   = 5;
    localparam int OP_W    = 6;
    localparam int PRIM_HI = WORD_W - 1;
    localparam int PRIM_LO = WORD_W - PRIM_W;
    localparam int SUB_LO  = OP_W;
    localparam int SUB_HI  = SUB_LO + SUB_W - 1;
    localparam int OP_HI   = OP_W - 1;
    localparam int MID_W   = PRIM_LO - OP_W;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              strobe;
        logic [SUB_W-1:0]  sub;
        logic [OP_W-1:0]   op;
        logic              wb_sel;
    } issue_t;
endpackage

// File: rtl/xdec_classify.sv
module xdec_classify
    import xdec_pkg::*;
#(
    parameter logic [PRIM_W-1:0] EXT_PRIMARY = 6'h3E
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_ext,
    output logic [SUB_W-1:0]  sub,
    output logic [OP_W-1:0]   op
);
    always_comb begin
        is_ext = (word[PRIM_HI:PRIM_LO] == EXT_PRIMARY);
        sub    = word[SUB_HI:SUB_LO];
        op     = word[OP_HI:0];
    end
endmodule

// File: rtl/xdec_rewrite.sv
module xdec_rewrite
    import xdec_pkg::*;
#(
    parameter logic [OP_W-1:0] SUBST_FUNCT = 6'h25
) (
    input  logic [WORD_W-1:0] word,
    input  logic              is_ext,
    output logic [WORD_W-1:0] issued
);
    logic [MID_W-1:0] mid;

    always_comb begin
        mid = word[PRIM_LO-1:OP_W];
        if (is_ext) begin
            issued = {{PRIM_W{1'b0}}, mid, SUBST_FUNCT};
        end else begin
            issued = word;
        end
    end
endmodule

// File: rtl/xdec_predecode.sv
module xdec_predecode
    import xdec_pkg::*;
#(
    parameter logic [PRIM_W-1:0] EXT_PRIMARY = 6'h3E,
    parameter logic [OP_W-1:0]   SUBST_FUNCT = 6'h25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_word,
    output logic              issue_valid,
    output logic [WORD_W-1:0] issue_word,
    output logic              xif_strobe,
    output logic [SUB_W-1:0]  xif_sub,
    output logic [OP_W-1:0]   xif_op,
    output logic              wb_from_xif
);
    logic              is_ext;
    logic [SUB_W-1:0]  sub_f;
    logic [OP_W-1:0]   op_f;
    logic [WORD_W-1:0] rewritten;
    issue_t            stage_d, stage_q;

    xdec_classify #(.EXT_PRIMARY(EXT_PRIMARY)) classify_i (
        .word   (fetch_word),
        .is_ext (is_ext),
        .sub    (sub_f),
        .op     (op_f)
    );

    xdec_rewrite #(.SUBST_FUNCT(SUBST_FUNCT)) rewrite_i (
        .word   (fetch_word),
        .is_ext (is_ext),
        .issued (rewritten)
    );

    always_comb begin
        stage_d = '0;
        if (fetch_valid) begin
            stage_d.vld    = 1'b1;
            stage_d.word   = rewritten;
            stage_d.strobe = is_ext;
            stage_d.wb_sel = is_ext;
            if (is_ext) begin
                stage_d.sub = sub_f;
                stage_d.op  = op_f;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign issue_valid = stage_q.vld;
    assign issue_word  = stage_q.word;
    assign xif_strobe  = stage_q.strobe;
    assign xif_sub     = stage_q.sub;
    assign xif_op      = stage_q.op;
    assign wb_from_xif = stage_q.wb_sel;
endmodule

// File: rtl/xdec_predecode_chk.sv
module xdec_predecode_chk
    import xdec_pkg::*;
#(
    parameter logic [PRIM_W-1:0] EXT_PRIMARY = 6'h3E,
    parameter logic [OP_W-1:0]   SUBST_FUNCT = 6'h25
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic [WORD_W-1:0] fetch_word,
    input logic              issue_valid,
    input logic [WORD_W-1:0] issue_word,
    input logic              xif_strobe,
    input logic [SUB_W-1:0]  xif_sub,
    input logic [OP_W-1:0]   xif_op,
    input logic              wb_from_xif
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R2
    native_pass_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(fetch_valid) && ($past(fetch_word[PRIM_HI:PRIM_LO]) != EXT_PRIMARY)
        |-> (issue_word == $past(fetch_word)) && issue_valid && !xif_strobe);

    // R4
    ext_rewrite_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(fetch_valid) && ($past(fetch_word[PRIM_HI:PRIM_LO]) == EXT_PRIMARY)
        |-> (issue_word[PRIM_HI:PRIM_LO] == '0) && (issue_word[OP_HI:0] == SUBST_FUNCT)
            && (issue_word[PRIM_LO-1:OP_W] == $past(fetch_word[PRIM_LO-1:OP_W])) && issue_valid);

    // R5
    ext_fields_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(fetch_valid) && ($past(fetch_word[PRIM_HI:PRIM_LO]) == EXT_PRIMARY)
        |-> xif_strobe && (xif_sub == $past(fetch_word[SUB_HI:SUB_LO]))
            && (xif_op == $past(fetch_word[OP_HI:0])));

    // R6
    wb_sel_chk: assert property (@(posedge clk) disable iff (rst)
        wb_from_xif == xif_strobe);

    // R7
    bubble_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(fetch_valid)
        |-> !issue_valid && (issue_word == '0) && !xif_strobe && !wb_from_xif);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !xif_strobe |-> (xif_sub == '0) && (xif_op == '0));
endmodule

bind xdec_predecode xdec_predecode_chk #(
    .EXT_PRIMARY(EXT_PRIMARY),
    .SUBST_FUNCT(SUBST_FUNCT)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_word  (fetch_word),
    .issue_valid (issue_valid),
    .issue_word  (issue_word),
    .xif_strobe  (xif_strobe),
    .xif_sub     (xif_sub),
    .xif_op      (xif_op),
    .wb_from_xif (wb_from_xif)
);

// File: tb/xdec_predecode_tb_top.sv
module xdec_predecode_tb_top;
    localparam logic [5:0] EXT = 6'h3E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        issue_valid;
    logic [31:0] issue_word;
    logic        xif_strobe;
    logic [4:0]  xif_sub;
    logic [5:0]  xif_op;
    logic        wb_from_xif;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xdec_predecode dut_i (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .issue_valid(issue_valid), .issue_word(issue_word), .xif_strobe(xif_strobe),
        .xif_sub(xif_sub), .xif_op(xif_op), .wb_from_xif(wb_from_xif)
    );

    function automatic logic [31:0] exp_word(input logic v, input logic [31:0] w);
        if (!v) return 32'h0;
        if (w[31:26] == EXT) return {6'd0, w[25:6], 6'h25};
        return w;
    endfunction

    function automatic logic exp_ext(input logic v, input logic [31:0] w);
        return v && (w[31:26] == EXT);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_all(input logic v, input logic [31:0] w, input string ctx);
        logic e;
        e = exp_ext(v, w);
        chk({ctx, " R7 issue_valid"}, {31'd0, issue_valid}, {31'd0, v});
        chk({ctx, " R2/R4 issue_word"}, issue_word, exp_word(v, w));
        chk({ctx, " R5 strobe"}, {31'd0, xif_strobe}, {31'd0, e});
        chk({ctx, " R5/R8 sub"}, {27'd0, xif_sub}, e ? {27'd0, w[10:6]} : 32'd0);
        chk({ctx, " R5/R8 op"}, {26'd0, xif_op}, e ? {26'd0, w[5:0]} : 32'd0);
        chk({ctx, " R6 wb_from_xif"}, {31'd0, wb_from_xif}, {31'd0, e});
    endtask

    task automatic step(input logic v, input logic [31:0] w, input string ctx);
        fetch_valid = v;
        fetch_word  = w;
        @(posedge clk);
        @(negedge clk);
        check_all(v, w, ctx);
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        fetch_valid = 1'b1;
        fetch_word  = {EXT, 20'hABCDE, 6'h11};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs zero while in reset
        check_all(1'b0, 32'h0, "reset R1");
        rst = 1'b0;
        fetch_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all(1'b0, 32'h0, "post-reset R1");

        // directed corners
        step(1'b1, 32'h0000_0000, "nop R2");
        step(1'b1, 32'hFFFF_FFFF, "ones R2");
        step(1'b1, {6'h3F, 26'h3FF_FFFF}, "near-opc R3");
        step(1'b1, {6'h3D, 26'h155_5555}, "near-opc2 R3");
        step(1'b1, {EXT, 26'h3FF_FFFF}, "ext ones R4");
        step(1'b1, {EXT, 5'd1, 5'd2, 5'd3, 5'd31, 6'h3F}, "ext R5");
        step(1'b1, {EXT, 5'd0, 5'd0, 5'd7, 5'd0, 6'h00}, "ext zero R5");
        step(1'b0, {EXT, 26'h123_4567}, "bubble ext R7");
        step(1'b0, 32'hDEAD_BEEF, "bubble nat R7");
        step(1'b1, {EXT, 26'h000_0041}, "b2b1 R5");
        step(1'b1, {EXT, 26'h2AA_AAAA}, "b2b2 R5");
        step(1'b1, 32'h0123_4567, "after ext R8");

        for (int i = 0; i < 2000; i++) begin
            r = $urandom;
            if (($urandom % 3) == 0) r[31:26] = EXT;
            step(($urandom % 5) != 0, r, "random R2/R3/R4");
        end

        rst = 1'b1;
        fetch_valid = 1'b1;
        fetch_word = {EXT, 26'h1};
        @(posedge clk);
        @(negedge clk);
        check_all(1'b0, 32'h0, "mid reset R1");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule